// File: doc/BRIEF.md
# x86 Instruction Prefix Scanner

This block inspects the first bytes of an x86 instruction, held in a window of up to fifteen bytes. It walks the run of leading prefix bytes and reports what the run means to the rest of a decoder:
- how many bytes it used up;
- a vector of prefix flags;
- the selected segment override;
- the mandatory-prefix index used to pick an opcode-table column;
- the opcode map and the extra register operand carried by a VEX prefix;
- an error flag when a VEX prefix is cut off by the end of the window.

A mode input selects 64-bit or 32-bit decoding. The mode changes how bytes 0x40–0x4F and 0xC4/0xC5 are treated.

The scan itself is combinational. A one-cycle `start` strobe samples the window, its length and the mode, and registers every result. `done` pulses in the following cycle, and the results hold until the next strobe. There is no back-pressure: the caller issues `start` whenever it has a new window, and it must take the results while `done` is high or before it issues the next `start`.

Top module: `pfx_scan_top`

## Requirements
- R1: The edge that samples `start` high also captures all results, so `done` is 1 for exactly the next cycle. Results hold until the next `start`. Reset clears every output to 0.
- R2: Bytes 0x26, 0x2E, 0x3E, 0x64 and 0x65 each consume one byte and set `seg_sel` to ES=1, CS=2, DS=3, FS=4 or GS=5. When several appear, the last one wins. With none present, `seg_sel` is 0.
- R3: `pfx_flags` bit positions: lock=0, rep=1, repnz=2, opsz=3, adsz=4, B=5, X=6, R=7, W=8, vex=9, vexl=10. 0xF0 sets lock, 0x66 sets opsz and 0x67 sets adsz. 0xF3 sets rep and 0xF2 sets repnz. Of 0xF3 and 0xF2, only the last one seen stays set. Each of these bytes consumes one byte.
- R4: Without VEX, `mand_idx` is 2 if the last of F3/F2 is F3 and 3 if it is F2. With neither present, it is 1 when 0x66 was seen and 0 otherwise.
- R5: In 64-bit mode, a byte 0x40–0x4F is consumed. Its bits 0, 1, 2 and 3 set B, X, R and W, and it ends the scan. In 32-bit mode such a byte ends the scan without being consumed.
- R6: The scan stops at the first byte that is not a prefix, or at the end of the window (`win_len` bytes). `consumed` counts the prefix bytes taken, from 0 up to 15.
- R7: For 0xC5 followed by byte P, the scanner consumes 2 bytes. R = not P[7], vexl = P[2], vex_reg = not P[6:3]. `map_valid` is 1 and `map_sel` is 1.
- R8: For 0xC4 followed by P and Q, the scanner consumes 3 bytes. R, X and B are the inverses of P[7], P[6] and P[5], but B is forced to 0 in 32-bit mode. `map_sel` = P[4:0], W = Q[7], vexl = Q[2], vex_reg = not Q[6:3].
- R9: In 32-bit mode, 0xC4 or 0xC5 counts as VEX only when bits 7:6 of the next byte are both 1. Otherwise the scan ends before it, with no error.
- R10: If a VEX start byte lacks the bytes its form needs within the window, `trunc_err` is 1. In that case `consumed` counts only the earlier prefixes, and no VEX field or flag is reported.
- R11: With VEX, `mand_idx` takes the last VEX byte's bits 1:0. If that value is 0 and 0x66 was seen, it becomes 1. The rep and repnz flags are still reported.
- R12: Without VEX, `map_valid`, `map_sel`, `vex_reg`, vex and vexl are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sample window and register results |
| mode64 | input | 1 | 1 = 64-bit decoding, 0 = 32-bit |
| win_bytes | input | 120 | Window; byte k at bits 8k+7:8k |
| win_len | input | 4 | Number of valid window bytes |
| done | output | 1 | One-cycle result pulse |
| consumed | output | 4 | Prefix bytes consumed |
| pfx_flags | output | 11 | Prefix flag vector |
| seg_sel | output | 3 | Segment override code |
| mand_idx | output | 2 | Mandatory-prefix index |
| map_valid | output | 1 | Opcode map comes from VEX |
| map_sel | output | 5 | VEX opcode map |
| vex_reg | output | 4 | VEX extra register operand |
| trunc_err | output | 1 | VEX prefix truncated |

## Verification
Two functions can fire on the same scan. A legacy prefix can sit directly before a VEX prefix, so the operand-size promotion of the mandatory index must merge with the VEX pp field. A repnz prefix before a VEX prefix must keep its flag while VEX replaces its index. Windows such as 66 C5 78 and F2 C4 03 7A provoke these overlaps. Each is judged by the full set of registered results in the `done` cycle. Truncation is also placed right after legacy prefixes, to show that they are still counted.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int NF = 11;
  localparam int F_LOCK  = 0;
  localparam int F_REP   = 1;
  localparam int F_REPNZ = 2;
  localparam int F_OPSZ  = 3;
  localparam int F_ADSZ  = 4;
  localparam int F_B     = 5;
  localparam int F_X     = 6;
  localparam int F_R     = 7;
  localparam int F_W     = 8;
  localparam int F_VEX   = 9;
  localparam int F_VEXL  = 10;

  typedef enum logic [3:0] {
    BC_OTHER, BC_SEG, BC_OPSZ, BC_ADSZ, BC_LOCK,
    BC_REP, BC_REPNZ, BC_REX, BC_VEX2, BC_VEX3
  } bclass_e;

  typedef struct packed {
    logic       r;
    logic       x;
    logic       b;
    logic       w;
    logic       l;
    logic [1:0] pp;
    logic [4:0] map;
    logic [3:0] vreg;
  } vex_f_t;

  function automatic logic [2:0] seg_code(input logic [7:0] v);
    case (v)
      8'h26:   seg_code = 3'd1;
      8'h2E:   seg_code = 3'd2;
      8'h3E:   seg_code = 3'd3;
      8'h64:   seg_code = 3'd4;
      8'h65:   seg_code = 3'd5;
      default: seg_code = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/pfx_byte_class.sv
module pfx_byte_class
  import pfx_pkg::*;
(
  input  logic [7:0] byte_in,
  output bclass_e    cls
);
  always_comb begin
    unique case (byte_in) inside
      8'h26, 8'h2E, 8'h3E, 8'h64, 8'h65: cls = BC_SEG;
      8'h66:          cls = BC_OPSZ;
      8'h67:          cls = BC_ADSZ;
      8'hF0:          cls = BC_LOCK;
      8'hF3:          cls = BC_REP;
      8'hF2:          cls = BC_REPNZ;
      [8'h40:8'h4F]:  cls = BC_REX;
      8'hC5:          cls = BC_VEX2;
      8'hC4:          cls = BC_VEX3;
      default:        cls = BC_OTHER;
    endcase
  end
endmodule

// File: rtl/pfx_walk.sv
module pfx_walk
  import pfx_pkg::*;
#(
  parameter int NB = 15,
  parameter int CW = $clog2(NB + 1)
)(
  input  logic                 mode64,
  input  logic [CW-1:0]        len,
  input  bclass_e [NB-1:0]     cls,
  input  logic [NB+1:0][7:0]   bw,
  output logic [CW-1:0]        cnt,
  output logic [2:0]           seg,
  output logic                 lock,
  output logic                 opsz,
  output logic                 adsz,
  output logic                 rep,
  output logic                 repnz,
  output logic [1:0]           mand_leg,
  output logic                 rex_hit,
  output logic [3:0]           rex_nib,
  output logic                 vex_hit,
  output logic                 vex_long,
  output logic [CW-1:0]        vex_at,
  output logic                 trunc
);
  logic active;

  always_comb begin
    active   = 1'b1;
    cnt      = '0;
    seg      = '0;
    lock     = 1'b0;
    opsz     = 1'b0;
    adsz     = 1'b0;
    rep      = 1'b0;
    repnz    = 1'b0;
    mand_leg = 2'd0;
    rex_hit  = 1'b0;
    rex_nib  = 4'd0;
    vex_hit  = 1'b0;
    vex_long = 1'b0;
    vex_at   = '0;
    trunc    = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (active) begin
        if (i >= int'(len)) begin
          active = 1'b0;                       // R6 window end
        end else begin
          case (cls[i])
            BC_SEG:  begin seg  = seg_code(bw[i]); cnt = CW'(i + 1); end  // R2 last wins
            BC_OPSZ: begin opsz = 1'b1; cnt = CW'(i + 1); end
            BC_ADSZ: begin adsz = 1'b1; cnt = CW'(i + 1); end
            BC_LOCK: begin lock = 1'b1; cnt = CW'(i + 1); end
            BC_REP: begin
              rep = 1'b1; repnz = 1'b0; mand_leg = 2'd2; cnt = CW'(i + 1);
            end
            BC_REPNZ: begin
              repnz = 1'b1; rep = 1'b0; mand_leg = 2'd3; cnt = CW'(i + 1);
            end
            BC_REX: begin                      // R5
              if (mode64) begin
                rex_hit = 1'b1;
                rex_nib = bw[i][3:0];
                cnt     = CW'(i + 1);
              end
              active = 1'b0;
            end
            BC_VEX2, BC_VEX3: begin            // R7 R8 R9 R10
              if (i + 1 >= int'(len))
                trunc = 1'b1;
              else if (!mode64 && bw[i+1][7:6] != 2'b11)
                trunc = 1'b0;
              else if (cls[i] == BC_VEX3 && i + 2 >= int'(len))
                trunc = 1'b1;
              else begin
                vex_hit  = 1'b1;
                vex_long = (cls[i] == BC_VEX3);
                vex_at   = CW'(i);
                cnt      = (cls[i] == BC_VEX3) ? CW'(i + 3) : CW'(i + 2);
              end
              active = 1'b0;
            end
            default: active = 1'b0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pfx_vex_fields.sv
module pfx_vex_fields
  import pfx_pkg::*;
(
  input  logic       long_form,
  input  logic       mode64,
  input  logic [7:0] b1,
  input  logic [7:0] b2,
  output vex_f_t     f
);
  logic [7:0] last;

  always_comb begin
    last   = long_form ? b2 : b1;
    f.r    = ~b1[7];
    f.x    = long_form & ~b1[6];
    f.b    = long_form & mode64 & ~b1[5];   // R8 B dropped in 32-bit
    f.w    = long_form & b2[7];
    f.l    = last[2];
    f.pp   = last[1:0];
    f.map  = long_form ? b1[4:0] : 5'd1;
    f.vreg = ~last[6:3];
  end
endmodule

// File: rtl/pfx_scan_top.sv
module pfx_scan_top
  import pfx_pkg::*;
#(
  parameter int NB = 15,
  parameter int CW = $clog2(NB + 1)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            mode64,
  input  logic [NB*8-1:0] win_bytes,
  input  logic [CW-1:0]   win_len,
  output logic            done,
  output logic [CW-1:0]   consumed,
  output logic [NF-1:0]   pfx_flags,
  output logic [2:0]      seg_sel,
  output logic [1:0]      mand_idx,
  output logic            map_valid,
  output logic [4:0]      map_sel,
  output logic [3:0]      vex_reg,
  output logic            trunc_err
);
  logic [NB+1:0][7:0] bw;
  bclass_e [NB-1:0]   cls;
  logic [CW-1:0]      len_c;

  always_comb begin
    bw = '0;
    for (int k = 0; k < NB; k++) bw[k] = win_bytes[8*k +: 8];
    len_c = (int'(win_len) > NB) ? CW'(NB) : win_len;
  end

  for (genvar g = 0; g < NB; g++) begin : g_cls
    pfx_byte_class u_cls (.byte_in(bw[g]), .cls(cls[g]));
  end

  logic [CW-1:0] w_cnt, w_vat;
  logic [2:0]    w_seg;
  logic          w_lock, w_opsz, w_adsz, w_rep, w_repnz;
  logic [1:0]    w_mand;
  logic          w_rex, w_vex, w_long, w_trunc;
  logic [3:0]    w_nib;

  pfx_walk #(.NB(NB), .CW(CW)) u_walk (
    .mode64(mode64), .len(len_c), .cls(cls), .bw(bw),
    .cnt(w_cnt), .seg(w_seg), .lock(w_lock), .opsz(w_opsz), .adsz(w_adsz),
    .rep(w_rep), .repnz(w_repnz), .mand_leg(w_mand),
    .rex_hit(w_rex), .rex_nib(w_nib), .vex_hit(w_vex), .vex_long(w_long),
    .vex_at(w_vat), .trunc(w_trunc)
  );

  logic [CW:0] i1, i2;
  logic [7:0]  vb1, vb2;
  vex_f_t      vf;

  always_comb begin
    i1  = {1'b0, w_vat} + (CW+1)'(1);
    i2  = {1'b0, w_vat} + (CW+1)'(2);
    vb1 = bw[i1];
    vb2 = bw[i2];
  end

  pfx_vex_fields u_vex (.long_form(w_long), .mode64(mode64), .b1(vb1), .b2(vb2), .f(vf));

  logic [NF-1:0] n_flags;
  logic [1:0]    n_mand;

  always_comb begin
    n_flags          = '0;
    n_flags[F_LOCK]  = w_lock;
    n_flags[F_REP]   = w_rep;
    n_flags[F_REPNZ] = w_repnz;
    n_flags[F_OPSZ]  = w_opsz;
    n_flags[F_ADSZ]  = w_adsz;
    n_flags[F_B]     = (w_rex & w_nib[0]) | (w_vex & vf.b);
    n_flags[F_X]     = (w_rex & w_nib[1]) | (w_vex & vf.x);
    n_flags[F_R]     = (w_rex & w_nib[2]) | (w_vex & vf.r);
    n_flags[F_W]     = (w_rex & w_nib[3]) | (w_vex & vf.w);
    n_flags[F_VEX]   = w_vex;
    n_flags[F_VEXL]  = w_vex & vf.l;
    n_mand = w_vex ? vf.pp : w_mand;                 // R11
    if (n_mand == 2'd0 && w_opsz) n_mand = 2'd1;     // R4
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      consumed  <= '0;
      pfx_flags <= '0;
      seg_sel   <= '0;
      mand_idx  <= '0;
      map_valid <= 1'b0;
      map_sel   <= '0;
      vex_reg   <= '0;
      trunc_err <= 1'b0;
    end else begin
      done <= start;                                 // R1
      if (start) begin
        consumed  <= w_cnt;
        pfx_flags <= n_flags;
        seg_sel   <= w_seg;
        mand_idx  <= n_mand;
        map_valid <= w_vex;                          // R12
        map_sel   <= w_vex ? vf.map : 5'd0;
        vex_reg   <= w_vex ? vf.vreg : 4'd0;
        trunc_err <= w_trunc;
      end
    end
  end
endmodule

// File: rtl/pfx_scan_chk.sv
module pfx_scan_chk #(
  parameter int CW = 4
)(
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] win_len,
  input logic          done,
  input logic [CW-1:0] consumed,
  input logic [10:0]   pfx_flags,
  input logic [1:0]    mand_idx,
  input logic          map_valid,
  input logic [3:0]    vex_reg,
  input logic          trunc_err
);
  a_r1_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r1_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(consumed) && $stable(pfx_flags) && $stable(mand_idx));
  a_r3_rep_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pfx_flags[1] && pfx_flags[2]));
  a_r6_within_window: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> consumed <= $past(win_len));
  a_r4_rep_index: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pfx_flags[1] && !pfx_flags[9]) |-> mand_idx == 2'd2);
  a_r10_trunc_no_vex: assert property (@(posedge clk) disable iff (!rst_n)
    (done && trunc_err) |-> (!pfx_flags[9] && !map_valid));
  a_r12_map_tracks_vex: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (map_valid == pfx_flags[9]));
  a_r12_no_vreg_without_vex: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pfx_flags[9]) |-> (vex_reg == 4'd0 && !pfx_flags[10]));
endmodule

bind pfx_scan_top pfx_scan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .win_len(win_len), .done(done),
  .consumed(consumed), .pfx_flags(pfx_flags), .mand_idx(mand_idx),
  .map_valid(map_valid), .vex_reg(vex_reg), .trunc_err(trunc_err)
);

// File: tb/sim_pfx_scan_top.sv
`timescale 1ns/1ps
module sim_pfx_scan_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         mode64 = 1'b1;
  logic [119:0] win_bytes = '0;
  logic [3:0]   win_len = '0;
  logic         done;
  logic [3:0]   consumed;
  logic [10:0]  pfx_flags;
  logic [2:0]   seg_sel;
  logic [1:0]   mand_idx;
  logic         map_valid;
  logic [4:0]   map_sel;
  logic [3:0]   vex_reg;
  logic         trunc_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] bb [15];

  always #2 clk = ~clk;

  pfx_scan_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode64(mode64),
    .win_bytes(win_bytes), .win_len(win_len), .done(done),
    .consumed(consumed), .pfx_flags(pfx_flags), .seg_sel(seg_sel),
    .mand_idx(mand_idx), .map_valid(map_valid), .map_sel(map_sel),
    .vex_reg(vex_reg), .trunc_err(trunc_err)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic set4(input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] c, input logic [7:0] d);
    for (int k = 0; k < 15; k++) bb[k] = 8'h90;
    bb[0] = a; bb[1] = b; bb[2] = c; bb[3] = d;
  endtask

  task automatic scan(input logic m64, input int n);
    @(negedge clk);
    for (int k = 0; k < 15; k++) win_bytes[8*k +: 8] = bb[k];
    win_len = 4'(n);
    mode64  = m64;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 done", done, 1);
  endtask

  task automatic expect_all(input string tag, input int cons, input int flg,
                            input int seg, input int mand, input int mv,
                            input int mp, input int vr, input int err);
    chk({tag, " consumed"}, consumed, cons);
    chk({tag, " flags"}, pfx_flags, flg);
    chk({tag, " seg"}, seg_sel, seg);
    chk({tag, " mand"}, mand_idx, mand);
    chk({tag, " map_valid"}, map_valid, mv);
    chk({tag, " map"}, map_sel, mp);
    chk({tag, " vreg"}, vex_reg, vr);
    chk({tag, " err"}, trunc_err, err);
  endtask

  task automatic t_reset;
    expect_all("R1 reset", 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 reset done", done, 0);
  endtask

  task automatic t_segments;
    set4(8'h26, 8'h2E, 8'h64, 8'h90); scan(1'b1, 4);
    expect_all("R2 last FS", 3, 0, 4, 0, 0, 0, 0, 0);
    set4(8'h65, 8'h3E, 8'h0F, 8'h90); scan(1'b0, 4);
    expect_all("R2 last DS", 2, 0, 3, 0, 0, 0, 0, 0);
    for (int k = 0; k < 15; k++) bb[k] = 8'h2E;
    scan(1'b1, 15);
    expect_all("R6 full window CS", 15, 0, 2, 0, 0, 0, 0, 0);
  endtask

  task automatic t_legacy;
    set4(8'h66, 8'h67, 8'hF0, 8'h0F); scan(1'b1, 4);
    expect_all("R3 R4 lock opsz adsz", 3, 'h019, 0, 1, 0, 0, 0, 0);
    set4(8'hF2, 8'hF3, 8'h66, 8'h90); scan(1'b1, 4);
    expect_all("R3 R4 rep last", 3, 'h00A, 0, 2, 0, 0, 0, 0);
    set4(8'hF3, 8'hF2, 8'h90, 8'h90); scan(1'b0, 4);
    expect_all("R3 R4 repnz last", 2, 'h004, 0, 3, 0, 0, 0, 0);
  endtask

  task automatic t_rex;
    set4(8'h66, 8'h4D, 8'h0F, 8'h90); scan(1'b1, 3);
    expect_all("R5 rex 64", 2, 'h1A8, 0, 1, 0, 0, 0, 0);
    set4(8'h4D, 8'h66, 8'h0F, 8'h90); scan(1'b1, 3);
    expect_all("R5 rex ends scan", 1, 'h1A0, 0, 0, 0, 0, 0, 0);
    set4(8'h66, 8'h4D, 8'h0F, 8'h90); scan(1'b0, 3);
    expect_all("R5 rex 32 opcode", 1, 'h008, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_window;
    set4(8'h66, 8'h66, 8'h66, 8'h66); scan(1'b1, 3);
    expect_all("R6 stop at len", 3, 'h008, 0, 1, 0, 0, 0, 0);
    scan(1'b1, 0);
    expect_all("R6 empty", 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_vex2;
    set4(8'hC5, 8'hB5, 8'h58, 8'h90); scan(1'b1, 3);
    expect_all("R7 vex2", 2, 'h600, 0, 1, 1, 1, 9, 0);
    set4(8'h66, 8'hC5, 8'h78, 8'h10); scan(1'b1, 4);
    expect_all("R11 R7 opsz+vex2", 3, 'h288, 0, 1, 1, 1, 0, 0);
  endtask

  task automatic t_vex3;
    set4(8'hC4, 8'h62, 8'hCD, 8'h90); scan(1'b1, 4);
    expect_all("R8 vex3", 3, 'h780, 0, 1, 1, 2, 6, 0);
    set4(8'hF2, 8'hC4, 8'h03, 8'h7A); scan(1'b1, 4);
    expect_all("R11 R8 repnz+vex3", 4, 'h2E4, 0, 2, 1, 3, 0, 0);
    set4(8'hC4, 8'hC2, 8'h05, 8'h90); scan(1'b0, 4);
    expect_all("R8 vex3 32 B ignored", 3, 'h600, 0, 1, 1, 2, 15, 0);
    scan(1'b1, 4);
    expect_all("R8 vex3 64 B", 3, 'h620, 0, 1, 1, 2, 15, 0);
  endtask

  task automatic t_vex32;
    set4(8'h66, 8'hC5, 8'h78, 8'h90); scan(1'b0, 4);
    expect_all("R9 not vex 32", 1, 'h008, 0, 1, 0, 0, 0, 0);
    set4(8'hC4, 8'h78, 8'h90, 8'h90); scan(1'b0, 2);
    expect_all("R9 c4 32 no err", 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_trunc;
    set4(8'h66, 8'hC5, 8'h90, 8'h90); scan(1'b1, 2);
    expect_all("R10 vex2 cut", 1, 'h008, 0, 1, 0, 0, 0, 1);
    set4(8'hC4, 8'hF0, 8'h90, 8'h90); scan(1'b1, 2);
    expect_all("R10 vex3 cut", 0, 0, 0, 0, 0, 0, 0, 1);
    set4(8'hC5, 8'h90, 8'h90, 8'h90); scan(1'b0, 1);
    expect_all("R10 vex 32 cut", 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_hold;
    set4(8'hC4, 8'h62, 8'hCD, 8'h90); scan(1'b1, 4);
    set4(8'h66, 8'h90, 8'h90, 8'h90);
    for (int k = 0; k < 15; k++) win_bytes[8*k +: 8] = bb[k];
    repeat (3) @(negedge clk);
    chk("R1 done low", done, 0);
    expect_all("R1 hold", 3, 'h780, 0, 1, 1, 2, 6, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 15; k++) bb[k] = 8'h90;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_segments();
    t_legacy();
    t_rex();
    t_window();
    t_vex2();
    t_vex3();
    t_vex32();
    t_trunc();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule